// File: doc/BRIEF.md
# Quadrature State-Tracking Position Counter

This block turns the two raw channels of an incremental quadrature encoder into a signed position count. It works in full four-state resolution, so every legal change of either channel moves the count by one. It watches the two-bit state of the channel pair rather than counting edges. A contact that chatters on one channel therefore steps the count up and down in turn, and the count lands on the right value once the contact settles.

Both channels come in asynchronously. They pass through a flip-flop synchronizer and are then compared, sample by sample, with the previous state. If both channels change between two samples, a state has been missed. The block raises a sticky error flag, which stays set until software-side logic pulses the clear input, and it leaves the count untouched. A one-cycle step pulse and a direction level go with every count update.

Top module: `quad_tracker`

## Requirements
- R1: After reset, `position` is 0, `sync_err` is 0 and `step` is 0. The channel levels present when reset is released are taken as the starting state and cause neither a step nor an error.
- R2: With the state written as {A,B}, moving through the sequence 00, 01, 11, 10, 00 adds one to `position` per state. Each such step produces a one-cycle `step` pulse with `dir_up` = 1.
- R3: Moving through that sequence in reverse order subtracts one per state, with a one-cycle `step` pulse and `dir_up` = 0.
- R4: Chatter on a single channel is followed state by state. After an even number of toggles of one channel, `position` is back at its value from before the chatter.
- R5: When both channels change between two samples, `sync_err` goes to 1. No `step` pulse is produced and `position` does not change.
- R6: `sync_err` stays at 1 until `err_clr` is high at a clock edge. If a new double change is detected in the same cycle as `err_clr`, the flag stays set.
- R7: `position` is a 16-bit two's-complement value that wraps. One step down from 0x0000 gives 0xFFFF, and one step up from 0xFFFF gives 0x0000.
- R8: With the default two synchronizer stages, a channel change that is set up before a rising clock edge shows on `position` and `step` after the third rising edge, counting that edge as the first.
- R9: While both channels are stable, `step` stays 0 and `position` and `dir_up` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all decoding runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_a | input | 1 | Raw encoder channel A, asynchronous |
| chan_b | input | 1 | Raw encoder channel B, asynchronous |
| err_clr | input | 1 | Clears the sticky sync-error flag |
| position | output | CW (16) | Signed two's-complement position count |
| dir_up | output | 1 | Direction of the most recent step, 1 for up |
| step | output | 1 | One-cycle pulse on each count update |
| sync_err | output | 1 | Sticky flag: both channels changed in one sample |

## Verification
The properties assume that at most one channel changes per synchronized sample, except where a double change is applied on purpose to provoke the error. They also assume the inputs are held for at least one clock, so that no change falls between samples. The stimulus drives the channels only at falling clock edges, holds each level for one clock or more, and makes both channels change together only in the tests that target the error flag. Under these conditions every count change is exactly plus or minus one and always comes with a step pulse.

// File: rtl/quad_tracker.sv
`timescale 1ns/1ps
module quad_tracker #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_a,
  input  logic          chan_b,
  input  logic          err_clr,
  output logic [CW-1:0] position,
  output logic          dir_up,
  output logic          step,
  output logic          sync_err
);
  localparam int             FW        = $clog2(SYNC_STAGES + 2);
  localparam logic [FW-1:0]  FILL_LAST = FW'(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] sa, sb;
  logic [1:0]             prev_idx;
  logic [FW-1:0]          fill;

  // Gray state {A,B} -> position index along the forward sequence
  wire  [1:0] cur_idx = {sa[SYNC_STAGES-1], sa[SYNC_STAGES-1] ^ sb[SYNC_STAGES-1]};
  wire        primed  = (fill == FILL_LAST);
  wire  [1:0] delta   = cur_idx - prev_idx;
  wire        fwd     = primed && (delta == 2'd1);
  wire        bwd     = primed && (delta == 2'd3);
  wire        dbl     = primed && (delta == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa       <= '0;
      sb       <= '0;
      prev_idx <= '0;
      fill     <= '0;
      position <= '0;
      dir_up   <= 1'b0;
      step     <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      sa       <= {sa[SYNC_STAGES-2:0], chan_a};
      sb       <= {sb[SYNC_STAGES-2:0], chan_b};
      prev_idx <= cur_idx;
      if (!primed) fill <= fill + 1'b1;
      step     <= fwd | bwd;
      if (fwd) begin
        position <= position + 1'b1;
        dir_up   <= 1'b1;
      end else if (bwd) begin
        position <= position - 1'b1;
        dir_up   <= 1'b0;
      end
      sync_err <= dbl | (sync_err & ~err_clr);
    end
  end
endmodule

// File: rtl/quad_tracker_chk.sv
`timescale 1ns/1ps
module quad_tracker_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_clr,
  input logic [CW-1:0] position,
  input logic          dir_up,
  input logic          step,
  input logic          sync_err
);
  a_r2_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((position - $past(position)) == CW'(1)) || (($past(position) - position) == CW'(1)));

  a_r2_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ((position - $past(position)) == CW'(1))) |-> dir_up);

  a_r3_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (($past(position) - position) == CW'(1))) |-> !dir_up);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> ($stable(position) && $stable(dir_up)));

  a_r5_err_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> (!step && $stable(position)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !err_clr) |=> sync_err);
endmodule

bind quad_tracker quad_tracker_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .position(position),
  .dir_up(dir_up), .step(step), .sync_err(sync_err)
);

// File: tb/quad_tracker_bench.sv
`timescale 1ns/1ps
module quad_tracker_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_a = 1'b1;
  logic          chan_b = 1'b1;
  logic          err_clr = 1'b0;
  logic [CW-1:0] position;
  logic          dir_up;
  logic          step;
  logic          sync_err;

  int checks = 0;
  int failures = 0;
  logic [1:0]    cur = 2'b11;
  logic [CW-1:0] exp_pos = '0;
  logic [CW:0]   expq[$];
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  quad_tracker u_quad_tracker (
    .clk(clk), .rst_n(rst_n), .chan_a(chan_a), .chan_b(chan_b), .err_clr(err_clr),
    .position(position), .dir_up(dir_up), .step(step), .sync_err(sync_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ord(input logic [1:0] s);
    case (s)
      2'b00: ord = 0;
      2'b01: ord = 1;
      2'b11: ord = 2;
      default: ord = 3;
    endcase
  endfunction

  task automatic go(input logic [1:0] nxt, input int hold);
    int d;
    d = (ord(nxt) - ord(cur) + 4) % 4;
    if (d == 1) begin exp_pos = exp_pos + 1'b1; expq.push_back({1'b1, exp_pos}); end
    if (d == 3) begin exp_pos = exp_pos - 1'b1; expq.push_back({1'b0, exp_pos}); end
    {chan_a, chan_b} = nxt;
    cur = nxt;
    repeat (hold) @(negedge clk);
  endtask

  function automatic logic [1:0] nxt_up(input logic [1:0] s);
    case (s)
      2'b00: nxt_up = 2'b01;
      2'b01: nxt_up = 2'b11;
      2'b11: nxt_up = 2'b10;
      default: nxt_up = 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] nxt_dn(input logic [1:0] s);
    case (s)
      2'b00: nxt_dn = 2'b10;
      2'b10: nxt_dn = 2'b11;
      2'b11: nxt_dn = 2'b01;
      default: nxt_dn = 2'b00;
    endcase
  endfunction

  // Scoreboard monitor: every step pulse must match the next expected item
  always @(negedge clk) begin
    if (rst_n && step) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5 R9 unexpected step", int'(position), int'(exp_pos));
      end else begin
        logic [CW:0] e;
        e = expq.pop_front();
        chk(position == e[CW-1:0], "R2 R3 position", int'(position), int'(e[CW-1:0]));
        chk(dir_up == e[CW], "R2 R3 dir_up", int'(dir_up), int'(e[CW]));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(position == '0, "R1 position", int'(position), 0);
    chk(sync_err == 1'b0, "R1 sync_err", int'(sync_err), 0);
    chk(step == 1'b0, "R1 step", int'(step), 0);

    // R8 latency: 11 -> 10 is a forward step
    go(2'b10, 2);
    chk(position == 16'd0, "R8 before third edge", int'(position), 0);
    @(negedge clk);
    chk(position == 16'd1, "R8 at third edge", int'(position), 1);
    repeat (3) @(negedge clk);

    // R2 forward run
    for (int i = 0; i < 8; i++) go(nxt_up(cur), 3);
    repeat (4) @(negedge clk);
    chk(position == 16'd9, "R2 forward total", int'(position), 9);

    // R3 reverse run through zero, R7 wrap
    for (int i = 0; i < 12; i++) go(nxt_dn(cur), 3);
    repeat (4) @(negedge clk);
    chk(position == 16'hFFFD, "R7 wrap below zero", int'(position), 'hFFFD);
    chk(dir_up == 1'b0, "R3 dir_up", int'(dir_up), 0);
    for (int i = 0; i < 3; i++) go(nxt_up(cur), 3);
    repeat (4) @(negedge clk);
    chk(position == 16'h0000, "R7 wrap back to zero", int'(position), 0);

    // R9 idle hold
    snap = position;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(step == 1'b0 && position == snap && dir_up == 1'b1, "R9 idle", int'(position), int'(snap));
    end

    // R4 chatter on channel B, one clock per level, even toggle count
    snap = position;
    for (int i = 0; i < 6; i++) go({cur[1], ~cur[0]}, 1);
    repeat (5) @(negedge clk);
    chk(position == snap, "R4 chatter net zero", int'(position), int'(snap));

    // R5 double change
    go(~cur, 5);
    chk(sync_err == 1'b1, "R5 flag set", int'(sync_err), 1);
    chk(position == snap, "R5 position held", int'(position), int'(snap));

    // R6 sticky, then clear
    repeat (5) @(negedge clk);
    chk(sync_err == 1'b1, "R6 sticky", int'(sync_err), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(sync_err == 1'b0, "R6 cleared", int'(sync_err), 0);

    // R6 new error in the same cycle as a clear: set wins
    go(~cur, 2);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(sync_err == 1'b1, "R6 set beats clear", int'(sync_err), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(sync_err == 1'b0, "R6 final clear", int'(sync_err), 0);

    // Stepping still works after the error
    go(nxt_dn(cur), 5);
    chk(position == exp_pos, "R3 after error", int'(position), int'(exp_pos));

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 R3 missing steps", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule